// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the bus-word address stream for the memory-mapped side of one DMA transfer that is shaped as a rectangle. A transfer has Y rows of X bytes each. Every row begins one stride beyond the start of the row before it. Within a row the address advances by the bus width on each accepted beat, so a row takes ceil(X / bus bytes) beats. Each beat carries two markers: one for the last beat of a row and one for the last beat of the whole rectangle.

A queue controller loads a request while the block is idle. The request holds a base address, a row stride, the X and Y counts (each written as the count minus one), a cyclic flag and a transfer ID. When the last beat of a normal transfer is accepted, the block returns a one-cycle completion pulse that carries the ID. In cyclic mode the block replays the same rectangle from the base address without end and gives no completion pulse. Dropping the enable input stops the stream at the next beat boundary and returns the block to idle.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, and `beat_valid` and `done_valid` are 0.
- R2: A request is taken only in a cycle where `req_valid`, `enable` and `req_ready` are all 1. While the block is busy, a request has no effect on the beat stream, and with `enable` at 0 no request is taken.
- R3: Within a row, beat k has address row_start + k * 2^BUS_LOG2. The row has (`req_xlen_m1` >> BUS_LOG2) + 1 beats, which is ceil(X / bus bytes) with X = `req_xlen_m1` + 1.
- R4: Row r starts at base + r * stride, computed modulo 2^ADDR_W.
- R5: The rectangle has `req_ylen_m1` + 1 rows. A value of 0 in both counts yields exactly one beat, and that beat carries both markers.
- R6: The block clears the low BUS_LOG2 bits of the base and of the stride, so every address it emits is aligned to the bus width.
- R7: `beat_row_last` is 1 only on the last beat of each row. `beat_final` is 1 only on the last beat of the last row, and whenever it is 1, `beat_row_last` is also 1.
- R8: While `beat_valid` is 1 and `beat_ready` is 0, the address and both markers stay unchanged.
- R9: One cycle after the final beat of a non-cyclic transfer is accepted, `done_valid` is 1 for exactly one cycle with `done_id` equal to the request ID. In that same cycle `req_ready` is 1.
- R10: With `req_cyclic` set, the beat after the final beat is at the base address again, and `done_valid` stays 0.
- R11: If `enable` is 0 while a transfer runs, `beat_valid` is 0 in that cycle and the block is idle from the next cycle, with no completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run permission; low aborts a running transfer |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_base | input | ADDR_W | Rectangle base address |
| req_stride | input | ADDR_W | Distance between row starts |
| req_xlen_m1 | input | LEN_W | Row length in bytes minus one |
| req_ylen_m1 | input | LEN_W | Row count minus one |
| req_cyclic | input | 1 | Replay the rectangle endlessly |
| req_id | input | ID_W | Transfer ID returned on completion |
| beat_ready | input | 1 | Consumer accepts the current beat |
| beat_valid | output | 1 | Beat address valid |
| beat_addr | output | ADDR_W | Bus-word address of the beat |
| beat_row_last | output | 1 | Last beat of a row |
| beat_final | output | 1 | Last beat of the rectangle |
| done_valid | output | 1 | One-cycle completion pulse |
| done_id | output | ID_W | ID of the completed transfer |

## Verification
The bench uses rows whose length is not a whole number of bus words, so a row-beat count rounded down instead of up would drop the last beat and misplace the row marker. It uses a base and a stride that are not aligned; a design that skipped the masking would emit stray low address bits or drift from row to row. Back-pressure that changes from cycle to cycle would show any advance made without an accepted beat. In the cyclic run and the aborted run, a design that pulsed completion or failed to wrap to the base would disagree with the reference queue on the first beat after the final one.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } dma2d_state_e;
endpackage

// File: rtl/dma2d_span_counter.sv
module dma2d_span_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] lim,
    output logic         at_end
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign at_end = (cnt_q == lim);
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
    import dma2d_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 16,
    parameter int BUS_LOG2 = 2,
    parameter int ID_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [ADDR_W-1:0] req_stride,
    input  logic [LEN_W-1:0]  req_xlen_m1,
    input  logic [LEN_W-1:0]  req_ylen_m1,
    input  logic              req_cyclic,
    input  logic [ID_W-1:0]   req_id,
    input  logic              beat_ready,
    output logic              beat_valid,
    output logic [ADDR_W-1:0] beat_addr,
    output logic              beat_row_last,
    output logic              beat_final,
    output logic              done_valid,
    output logic [ID_W-1:0]   done_id
);
    localparam int                BUS_BYTES  = 1 << BUS_LOG2;
    localparam logic [ADDR_W-1:0] STEP       = ADDR_W'(BUS_BYTES);
    localparam logic [ADDR_W-1:0] ALIGN_KEEP = ~(ADDR_W'(BUS_BYTES - 1));

    typedef struct packed {
        dma2d_state_e      st;
        logic              cyc;
        logic [ID_W-1:0]   id;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] stride;
        logic [ADDR_W-1:0] row_start;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  beats_m1;
        logic [LEN_W-1:0]  rows_m1;
        logic              done;
    } regs_t;

    regs_t r_d, r_q;

    logic running, accept, fire, row_end, rows_end, pass_end;
    logic beat_clr, beat_inc, row_clr, row_inc;

    assign running  = (r_q.st == ST_RUN);
    assign accept   = !running && enable && req_valid;
    assign fire     = running && enable && beat_ready;
    assign pass_end = row_end && rows_end;

    // Beat-in-row and row-in-pass counters
    assign beat_clr = accept || !running || (fire && row_end);
    assign beat_inc = fire && !row_end;
    assign row_clr  = accept || !running || (fire && pass_end);
    assign row_inc  = fire && row_end && !rows_end;

    dma2d_span_counter #(.W(LEN_W)) u_beat_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (beat_clr),
        .inc    (beat_inc),
        .lim    (r_q.beats_m1),
        .at_end (row_end)
    );

    dma2d_span_counter #(.W(LEN_W)) u_row_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (row_clr),
        .inc    (row_inc),
        .lim    (r_q.rows_m1),
        .at_end (rows_end)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (accept) begin
            r_d.st        = ST_RUN;
            r_d.cyc       = req_cyclic;
            r_d.id        = req_id;
            r_d.base      = req_base & ALIGN_KEEP;
            r_d.stride    = req_stride & ALIGN_KEEP;
            r_d.row_start = req_base & ALIGN_KEEP;
            r_d.addr      = req_base & ALIGN_KEEP;
            r_d.beats_m1  = req_xlen_m1 >> BUS_LOG2;
            r_d.rows_m1   = req_ylen_m1;
        end else if (running && !enable) begin
            r_d.st = ST_IDLE;
        end else if (fire) begin
            if (!row_end) begin
                r_d.addr = r_q.addr + STEP;
            end else if (!rows_end) begin
                r_d.row_start = r_q.row_start + r_q.stride;
                r_d.addr      = r_q.row_start + r_q.stride;
            end else if (r_q.cyc) begin
                r_d.row_start = r_q.base;
                r_d.addr      = r_q.base;
            end else begin
                r_d.st   = ST_IDLE;
                r_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    assign req_ready     = !running;
    assign beat_valid    = running && enable;
    assign beat_addr     = r_q.addr;
    assign beat_row_last = running && row_end;
    assign beat_final    = running && pass_end;
    assign done_valid    = r_q.done;
    assign done_id       = r_q.id;
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
    parameter int ADDR_W   = 32,
    parameter int BUS_LOG2 = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              beat_ready,
    input logic              beat_valid,
    input logic [ADDR_W-1:0] beat_addr,
    input logic              beat_row_last,
    input logic              beat_final,
    input logic              done_valid
);
    localparam logic [ADDR_W-1:0] LOW_BITS = ADDR_W'((1 << BUS_LOG2) - 1);
    localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(1 << BUS_LOG2);

    assert_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> ((beat_addr & LOW_BITS) == '0));

    assert_final_in_row_R7: assert property (@(posedge clk) disable iff (!rst_n)
        beat_final |-> beat_row_last);

    assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_ready) |=> (!beat_valid ||
            ($stable(beat_addr) && $stable(beat_row_last) && $stable(beat_final))));

    assert_step_in_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_ready && !beat_row_last) |=>
            (!beat_valid || (beat_addr == $past(beat_addr) + STEP)));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> req_ready);
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(
    .ADDR_W   (ADDR_W),
    .BUS_LOG2 (BUS_LOG2)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .beat_ready    (beat_ready),
    .beat_valid    (beat_valid),
    .beat_addr     (beat_addr),
    .beat_row_last (beat_row_last),
    .beat_final    (beat_final),
    .done_valid    (done_valid)
);

// File: tb/dma2d_addr_gen_test.sv
`timescale 1ns/1ps
module dma2d_addr_gen_test;
    localparam int AW = 32;
    localparam int LW = 16;
    localparam int BL = 2;
    localparam int IW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_base = '0;
    logic [AW-1:0] req_stride = '0;
    logic [LW-1:0] req_xlen_m1 = '0;
    logic [LW-1:0] req_ylen_m1 = '0;
    logic          req_cyclic = 1'b0;
    logic [IW-1:0] req_id = '0;
    logic          beat_ready = 1'b1;
    logic          beat_valid;
    logic [AW-1:0] beat_addr;
    logic          beat_row_last;
    logic          beat_final;
    logic          done_valid;
    logic [IW-1:0] done_id;

    always #4 clk = ~clk;

    dma2d_addr_gen #(.ADDR_W(AW), .LEN_W(LW), .BUS_LOG2(BL), .ID_W(IW)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_base(req_base), .req_stride(req_stride),
        .req_xlen_m1(req_xlen_m1), .req_ylen_m1(req_ylen_m1),
        .req_cyclic(req_cyclic), .req_id(req_id),
        .beat_ready(beat_ready), .beat_valid(beat_valid),
        .beat_addr(beat_addr), .beat_row_last(beat_row_last),
        .beat_final(beat_final), .done_valid(done_valid), .done_id(done_id)
    );

    typedef struct packed {
        logic [AW-1:0] a;
        logic          rl;
        logic          fin;
    } beat_t;

    beat_t         expq[$];
    beat_t         tmpl[$];
    bit            m_cyc;
    logic [IW-1:0] m_id;
    bit            done_exp;
    logic [IW-1:0] done_id_exp;
    int            n_chk;
    int            n_fail;
    int            cyc_no;
    bit            stall_mode;
    string         cur_req;

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_up();
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic void build_pass(input logic [AW-1:0] base, input logic [AW-1:0] stride,
                                       input int xm1, input int ym1);
        logic [AW-1:0] b;
        logic [AW-1:0] s;
        int nb;
        b  = base & ~AW'(3);
        s  = stride & ~AW'(3);
        nb = (xm1 / 4) + 1;
        tmpl.delete();
        for (int r = 0; r <= ym1; r++) begin
            for (int k = 0; k < nb; k++) begin
                beat_t e;
                e.a   = b + AW'(r) * s + AW'(k * 4);
                e.rl  = (k == nb - 1);
                e.fin = (k == nb - 1) && (r == ym1);
                tmpl.push_back(e);
            end
        end
    endfunction

    // Called at a falling edge with inputs already set for the coming rising edge.
    task automatic step();
        bit exp_valid;
        beat_t e;
        beat_ready = stall_mode ? ((cyc_no % 3) != 1) : 1'b1;
        #1;
        exp_valid = (expq.size() > 0) && enable;
        chk(beat_valid == exp_valid, cur_req, "beat_valid", beat_valid, exp_valid);
        if (exp_valid && beat_valid) begin
            chk(beat_addr == expq[0].a, cur_req, "beat_addr", beat_addr, expq[0].a);
            chk(beat_row_last == expq[0].rl, "R7", "beat_row_last", beat_row_last, expq[0].rl);
            chk(beat_final == expq[0].fin, "R7", "beat_final", beat_final, expq[0].fin);
        end
        chk(req_ready == (expq.size() == 0), cur_req, "req_ready", req_ready, expq.size() == 0);
        chk(done_valid == done_exp, "R9", "done_valid", done_valid, done_exp);
        if (done_exp)
            chk(done_id == done_id_exp, "R9", "done_id", done_id, done_id_exp);
        done_exp = 1'b0;
        if (expq.size() > 0 && !enable) begin
            expq.delete();
        end else if (exp_valid && beat_ready) begin
            e = expq.pop_front();
            if (e.fin) begin
                if (m_cyc) begin
                    foreach (tmpl[i]) expq.push_back(tmpl[i]);
                end else begin
                    done_exp    = 1'b1;
                    done_id_exp = m_id;
                end
            end
        end else if (expq.size() == 0 && req_valid && enable) begin
            build_pass(req_base, req_stride, int'(req_xlen_m1), int'(req_ylen_m1));
            foreach (tmpl[i]) expq.push_back(tmpl[i]);
            m_cyc = req_cyclic;
            m_id  = req_id;
        end
        @(posedge clk);
        @(negedge clk);
        cyc_no++;
    endtask

    task automatic request(input logic [AW-1:0] base, input logic [AW-1:0] stride,
                           input int xm1, input int ym1, input bit cyc, input int id);
        req_base    = base;
        req_stride  = stride;
        req_xlen_m1 = LW'(xm1);
        req_ylen_m1 = LW'(ym1);
        req_cyclic  = cyc;
        req_id      = IW'(id);
        req_valid   = 1'b1;
        step();
        req_valid   = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 2000 && (expq.size() > 0 || done_exp); i++) step();
        step();
    endtask

    initial begin
        n_chk = 0; n_fail = 0; cyc_no = 0; done_exp = 0; stall_mode = 0; m_cyc = 0; m_id = '0;
        @(negedge clk);
        @(negedge clk);
        // R1: state held in reset
        chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
        chk(beat_valid == 1'b0, "R1", "beat_valid", beat_valid, 0);
        chk(done_valid == 1'b0, "R1", "done_valid", done_valid, 0);
        rst_n = 1'b1;
        enable = 1'b1;
        cur_req = "R1";
        step();

        // R5: single beat, single row
        cur_req = "R5";
        request(32'h0000_0040, 32'h0, 0, 0, 1'b0, 3);
        drain();

        // R3 R4: aligned rectangle, 4 beats x 3 rows
        cur_req = "R3 R4";
        request(32'h0000_1000, 32'h0000_0100, 15, 2, 1'b0, 7);
        drain();

        // R6 R8: unaligned base and stride, partial word rows, back-pressure
        cur_req = "R6 R8";
        stall_mode = 1'b1;
        request(32'h0000_2003, 32'h0000_0043, 9, 3, 1'b0, 12);
        drain();
        stall_mode = 1'b0;

        // R4: stride wraps around the address space
        cur_req = "R4";
        request(32'hFFFF_FFF0, 32'h0000_0008, 7, 3, 1'b0, 1);
        drain();

        // R2: request while busy has no effect
        cur_req = "R2";
        request(32'h0000_3000, 32'h0000_0020, 11, 1, 1'b0, 20);
        request(32'h0000_9000, 32'h0000_0400, 3, 5, 1'b0, 21);
        request(32'h0000_A000, 32'h0000_0400, 3, 5, 1'b1, 22);
        drain();

        // R10: cyclic replay, then R11 abort by enable
        cur_req = "R10";
        request(32'h0000_5000, 32'h0000_0010, 7, 1, 1'b1, 9);
        for (int i = 0; i < 19; i++) step();
        stall_mode = 1'b1;
        for (int i = 0; i < 7; i++) step();
        stall_mode = 1'b0;
        cur_req = "R11";
        enable = 1'b0;
        step();
        enable = 1'b1;
        for (int i = 0; i < 4; i++) step();

        // R2 R11: enable low blocks a request
        cur_req = "R2 R11";
        enable = 1'b0;
        request(32'h0000_6000, 32'h0000_0010, 3, 0, 1'b0, 5);
        step();
        enable = 1'b1;
        for (int i = 0; i < 3; i++) step();

        // R11: abort in the middle of a normal transfer, no completion
        cur_req = "R11";
        request(32'h0000_7000, 32'h0000_0040, 31, 3, 1'b0, 17);
        for (int i = 0; i < 5; i++) step();
        enable = 1'b0;
        step();
        enable = 1'b1;
        for (int i = 0; i < 4; i++) step();

        // R9: back-to-back transfers after completion
        cur_req = "R9";
        request(32'h0000_8000, 32'h0000_0004, 2, 2, 1'b0, 30);
        drain();
        request(32'h0000_8800, 32'h0000_0000, 4, 0, 1'b0, 31);
        drain();

        finish_up();
    end
endmodule